// File: doc/BRIEF.md
# Flash Strobe Pulse Generator

This block drives the trigger line of a camera flash from the vertical timing of one image field. It watches the substrate-clear pulse train (SUBCK), which empties the sensor before exposure. It counts the rising edges of that train from the start of the field, and a programmed count marks the final pulse. When that pulse arrives, the strobe goes high. The strobe stays high through the exposure interval and drops when the sensor-gate (VSG) pulse transfers the charge out.

All three timing inputs are sampled on the pixel clock, and their edges are found by comparing two consecutive samples. A field begins on the falling edge of the vertical sync input. A single enable bit from a control register gates the output. When the enable bit is clear, the strobe is held low.

The top-level parameter `VSG_ON_RISE` selects which sensor-gate edge ends the strobe: the rising edge (the default) or the falling edge. `CNT_W` sets the width of the pulse counter and of the programmed count.

Top module: `flash_strobe_gen`

## Requirements
- R1: After a clock edge with `rst` high, `strobe` is 0 and the pulse count of the field is zero.
- R2: After any clock edge at which `strobe_en` is 0, `strobe` is 0.
- R3: Let N be the value of `subck_count`. Suppose `subck` is first sampled high at clock edge k, that this starts the N-th rising edge of `subck` since the field began, and that N is not 0. Then `strobe` is 1 after edge k+1, provided `strobe_en` is 1 at edge k+1.
- R4: Rising edges of `subck` earlier than the N-th do not raise `strobe`. The counter saturates at 2^CNT_W-1, so a count of 2^CNT_W-1 is still reachable.
- R5: With `VSG_ON_RISE`=1, suppose `vsg` is first sampled high at edge k. Then `strobe` is 0 after edge k+1.
- R6: The strobe is raised at most once per field. Further `subck` edges in the same field, whether before or after the sensor-gate edge, do not raise it again.
- R7: A falling edge of `vd` starts a new field and resets the pulse count. It is detected with the same two-edge latency as the other inputs. A `subck` rising edge detected in that same cycle is not counted.
- R8: If `subck_count` is 0, or the field has fewer than N `subck` rising edges, `strobe` stays low for that field.
- R9: If `strobe_en` falls while `strobe` is high, `strobe` is 0 after the next clock edge.
- R10: If the sensor-gate edge and the final `subck` edge are detected in the same cycle, the clear takes priority and `strobe` stays low.
- R11: With `VSG_ON_RISE`=0, the strobe is cleared on the falling edge of `vsg` instead, with the same two-edge latency, and a rising edge of `vsg` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_en | input | 1 | Enable bit from the control register |
| vd | input | 1 | Vertical sync; its falling edge starts a field |
| subck | input | 1 | Substrate-clear pulse train |
| vsg | input | 1 | Sensor-gate pulse |
| subck_count | input | CNT_W | Number of SUBCK pulses in the field (0 disables the strobe) |
| strobe | output | 1 | Registered flash trigger output |

## Verification
The bench builds two copies of the block side by side from the same stimulus.

- One copy keeps the default rising-edge clear. The other sets `VSG_ON_RISE`=0, so both clearing variants, and the rule that the unused `vsg` edge has no effect, are compared in every cycle.
- Both copies use `CNT_W`=4. This keeps the saturation point at 15 pulses, which is reachable inside one directed field, so the largest programmed count and the saturating counter are both exercised.

The directed fields cover a zero count, a short train, an over-long train, an enable drop mid-strobe and coincident set and clear events. Random fields follow the directed ones.

// File: rtl/fs_pkg.sv
package fs_pkg;
  // Which transition of a sampled input an edge detector reports
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } fs_edge_e;
endpackage

// File: rtl/fs_edge_det.sv
module fs_edge_det
  import fs_pkg::*;
#(
  parameter fs_edge_e POLARITY = EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic ev_o
);
  logic samp_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= sig_i;
      prev_q <= samp_q;
    end
  end

  generate
    if (POLARITY == EDGE_RISE) begin : g_rise
      assign ev_o = samp_q & ~prev_q;
    end else begin : g_fall
      assign ev_o = ~samp_q & prev_q;
    end
  endgenerate
endmodule

// File: rtl/fs_pulse_counter.sv
module fs_pulse_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             field_start,
  input  logic             pulse_rise,
  input  logic [CNT_W-1:0] target,
  output logic             last_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic [CNT_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + 1'b1;

  assign last_hit = pulse_rise & ~field_start & ~done_q &
                    (target != '0) & (cnt_next == {1'b0, target});

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (field_start) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (pulse_rise) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_next[CNT_W-1:0];
      if (last_hit) done_q <= 1'b1;
    end
  end

  // R7
  field_clear_chk: assert property (@(posedge clk) disable iff (rst)
    field_start |=> (cnt_q == '0) && !done_q);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse_rise && !field_start && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R6
  once_per_field_chk: assert property (@(posedge clk) disable iff (rst)
    last_hit |=> done_q && !last_hit);
endmodule

// File: rtl/fs_strobe_ctrl.sv
module fs_strobe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic set_ev,
  input  logic clear_ev,
  output logic strobe_o
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst)           strobe_q <= 1'b0;
    else if (!en)      strobe_q <= 1'b0;
    else if (clear_ev) strobe_q <= 1'b0;
    else if (set_ev)   strobe_q <= 1'b1;
  end

  assign strobe_o = strobe_q;

  // R2
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !strobe_q);

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clear_ev |=> !strobe_q);

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_q) |-> $past(set_ev && en));
endmodule

// File: rtl/flash_strobe_gen.sv
module flash_strobe_gen
  import fs_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter bit VSG_ON_RISE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_en,
  input  logic             vd,
  input  logic             subck,
  input  logic             vsg,
  input  logic [CNT_W-1:0] subck_count,
  output logic             strobe
);
  localparam fs_edge_e VSG_EDGE = VSG_ON_RISE ? EDGE_RISE : EDGE_FALL;

  logic field_start;
  logic subck_rise;
  logic vsg_ev;
  logic last_hit;

  fs_edge_det #(.POLARITY(EDGE_FALL)) u_vd_edge (
    .clk(clk), .rst(rst), .sig_i(vd), .ev_o(field_start)
  );

  fs_edge_det #(.POLARITY(EDGE_RISE)) u_subck_edge (
    .clk(clk), .rst(rst), .sig_i(subck), .ev_o(subck_rise)
  );

  fs_edge_det #(.POLARITY(VSG_EDGE)) u_vsg_edge (
    .clk(clk), .rst(rst), .sig_i(vsg), .ev_o(vsg_ev)
  );

  fs_pulse_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst),
    .field_start(field_start),
    .pulse_rise(subck_rise),
    .target(subck_count),
    .last_hit(last_hit)
  );

  fs_strobe_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .en(strobe_en),
    .set_ev(last_hit),
    .clear_ev(vsg_ev),
    .strobe_o(strobe)
  );

  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (subck_count == '0) |=> !$rose(strobe));

  // R5
  gate_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (vsg_ev && strobe) |=> !strobe);
endmodule

// File: tb/flash_strobe_gen_bench.sv
`timescale 1ns/1ps
module flash_strobe_gen_bench;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic vd = 1'b1;
  logic subck = 1'b0;
  logic vsg = 1'b0;
  logic [CNT_W-1:0] n = '0;
  logic strobe_r;
  logic strobe_f;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  flash_strobe_gen #(.CNT_W(CNT_W), .VSG_ON_RISE(1'b1)) u_flash_strobe_gen (
    .clk(clk), .rst(rst), .strobe_en(en), .vd(vd), .subck(subck),
    .vsg(vsg), .subck_count(n), .strobe(strobe_r)
  );

  flash_strobe_gen #(.CNT_W(CNT_W), .VSG_ON_RISE(1'b0)) u_flash_strobe_gen_fall (
    .clk(clk), .rst(rst), .strobe_en(en), .vd(vd), .subck(subck),
    .vsg(vsg), .subck_count(n), .strobe(strobe_f)
  );

  // Reference model state, built from the requirements
  bit h1_v, h2_v, h1_s, h2_s, h1_g, h2_g;
  int m_cnt;
  bit m_done;
  bit exp_r, exp_f;
  string tag_r, tag_f;

  function automatic void model_step();
    bit sub_r, vd_f, g_r, g_f, hit;
    if (rst) begin
      h1_v = 0; h2_v = 0; h1_s = 0; h2_s = 0; h1_g = 0; h2_g = 0;
      m_cnt = 0; m_done = 0; exp_r = 0; exp_f = 0;
      tag_r = "R1"; tag_f = "R1";
      return;
    end
    sub_r = h1_s & ~h2_s;
    vd_f  = ~h1_v & h2_v;
    g_r   = h1_g & ~h2_g;
    g_f   = ~h1_g & h2_g;
    hit   = 0;
    tag_r = "R4"; tag_f = "R11";
    if (vd_f) begin
      m_cnt = 0; m_done = 0; tag_r = "R7";
    end else if (sub_r) begin
      if (n == 0) tag_r = "R8";
      else if (m_done) tag_r = "R6";
      if (!m_done && n != 0 && m_cnt + 1 == int'(n)) hit = 1;
      if (hit) begin m_done = 1; tag_r = "R3"; end
      if (m_cnt < CMAX) m_cnt++;
    end
    if (hit && g_r) tag_r = "R10";
    else if (g_r) tag_r = "R5";
    if (!en && exp_r) tag_r = "R9";
    else if (!en) tag_r = "R2";
    exp_r = !en ? 1'b0 : g_r ? 1'b0 : hit ? 1'b1 : exp_r;
    exp_f = !en ? 1'b0 : g_f ? 1'b0 : hit ? 1'b1 : exp_f;
    h2_v = h1_v; h1_v = vd;
    h2_s = h1_s; h1_s = subck;
    h2_g = h1_g; h1_g = vsg;
  endfunction

  task automatic check(input bit got, input bit expv, input string tag);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s strobe got %0b expected %0b at %0t", tag, got, expv, $time);
    end
  endtask

  // One clock: let the edge happen, update the model, compare both copies
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    model_step();
    check(strobe_r, exp_r, tag_r);
    check(strobe_f, exp_f, tag_f);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic new_field(input logic [CNT_W-1:0] cnt);
    n = cnt; vd = 1'b0; idle(2); vd = 1'b1; idle(3);
  endtask

  task automatic sub_pulse();
    subck = 1'b1; idle(2); subck = 1'b0; idle(3);
  endtask

  task automatic gate_pulse();
    vsg = 1'b1; idle(3); vsg = 1'b0; idle(4);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    check(strobe_r, 1'b0, "R1");
    check(strobe_f, 1'b0, "R1");
    rst = 1'b0;
    idle(2);

    // R2: disabled, full field produces no strobe
    en = 1'b0;
    new_field(3);
    for (int i = 0; i < 3; i++) sub_pulse();
    check(strobe_r, 1'b0, "R2");
    gate_pulse();

    // R3 and R5: normal field, strobe bracketed by last SUBCK and VSG
    en = 1'b1;
    new_field(3);
    for (int i = 0; i < 3; i++) sub_pulse();
    check(strobe_r, 1'b1, "R3");
    check(strobe_f, 1'b1, "R3");
    vsg = 1'b1; idle(2);
    check(strobe_r, 1'b0, "R5");
    check(strobe_f, 1'b1, "R11");
    vsg = 1'b0; idle(2);
    check(strobe_f, 1'b0, "R11");
    idle(3);

    // R8: zero count, then too few pulses
    new_field(0);
    for (int i = 0; i < 4; i++) sub_pulse();
    check(strobe_r, 1'b0, "R8");
    gate_pulse();
    new_field(5);
    for (int i = 0; i < 2; i++) sub_pulse();
    check(strobe_r, 1'b0, "R8");
    gate_pulse();

    // R6: over-long train and pulses after the gate
    new_field(2);
    for (int i = 0; i < 4; i++) sub_pulse();
    check(strobe_r, 1'b1, "R6");
    gate_pulse();
    sub_pulse(); sub_pulse();
    check(strobe_r, 1'b0, "R6");

    // R7: new field restarts the count
    new_field(1);
    sub_pulse();
    check(strobe_r, 1'b1, "R7");
    gate_pulse();

    // R9: enable dropped while high
    new_field(1);
    sub_pulse();
    check(strobe_r, 1'b1, "R9");
    en = 1'b0; idle(1);
    check(strobe_r, 1'b0, "R9");
    en = 1'b1; idle(2);
    check(strobe_r, 1'b0, "R9");
    gate_pulse();

    // R10: last SUBCK edge and VSG rise together
    new_field(1);
    subck = 1'b1; vsg = 1'b1; idle(3);
    check(strobe_r, 1'b0, "R10");
    subck = 1'b0; vsg = 1'b0; idle(4);

    // R4: largest count, with saturation beyond it
    new_field(CNT_W'(CMAX));
    for (int i = 0; i < CMAX - 1; i++) sub_pulse();
    check(strobe_r, 1'b0, "R4");
    sub_pulse();
    check(strobe_r, 1'b1, "R4");
    sub_pulse(); sub_pulse();
    gate_pulse();

    // Random fields
    for (int f = 0; f < 60; f++) begin
      new_field(CNT_W'($urandom_range(0, 6)));
      for (int c = 0; c < 60; c++) begin
        if ($urandom_range(0, 3) == 0) subck = ~subck;
        if ($urandom_range(0, 15) == 0) vsg = ~vsg;
        en = ($urandom_range(0, 40) != 0);
        tick();
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule